// File: doc/BRIEF.md
# Two-Channel Pulse-Width Modulator with Common Time Base

The block drives two pulse-width-modulated outputs from one time base. A programmable prescaler divides the clock and produces a one-cycle step pulse. That pulse advances a free-running step counter that cycles through 255 states, 0 to 254. Each channel compares its own compare value against this common count.

The output of a channel is low while its compare value is above the count, and high otherwise. A compare value of 00h therefore keeps the output high at all times. A value of FFh keeps it low at all times, because the count never reaches 255.

Software programs the block through a small register port. It has a 2-bit address, a write strobe, 8-bit write data and combinational read data. Compare writes act at once, in the middle of a period if need be. A new divider value is picked up the next time the prescaler reloads.

The block has no data stream, so every pin is a plain control or status signal. No valid/ready handshake and no back-pressure apply.

Top module: `pwm_dual_top`

## Requirements
- R1: After reset, both compare registers and the divider register read 00h, and both outputs are high.
- R2: The prescaler issues one step every (D+1) clock cycles, where D is the divider value. A new divider value first sets the spacing after the step that follows the write.
- R3: The step counter advances by one on each step, going from 254 back to 0. It never holds 255, and it holds its value between steps.
- R4: A channel output is low when its compare value is greater than the step count, and high when it is less than or equal to it.
- R5: A compare value of 00h gives a constant high output, and FFh gives a constant low output.
- R6: A compare write changes the output in the clock cycle right after the write edge, without waiting for the end of the period.
- R7: Both channels are compared against the same step count.
- R8: Register addresses are: 0 = compare of channel 0, 1 = compare of channel 1, 2 = divider. Reading returns the stored value, and reading the divider gives the written value. Address 3 reads 00h and a write to it changes nothing.
- R9: With steady settings, each period lasts 255*(D+1) cycles, and the output of a channel with compare value C is low for C*(D+1) of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 2 | Register select |
| reg_wr_en | input | 1 | Write strobe for the selected register |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Combinational read data of the selected register |
| pwm_out | output | 2 | Channel outputs, bit n belongs to channel n |

## Verification
The bench builds the block with its default values: 8-bit registers, two channels and a 2-bit address. With these values the unused address 3 exists and the 255-state count wraps. With divider values of 0 to 3, full periods last at most about a thousand cycles, so many wraps, mid-period compare writes and divider changes around a reload occur within the run. One directed stretch with the divider at FFh exercises the widest prescaler count.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // role of a register-port address
  typedef enum logic [1:0] {
    ROLE_CMP    = 2'd0,
    ROLE_DIV    = 2'd1,
    ROLE_UNUSED = 2'd2
  } reg_role_e;

  function automatic reg_role_e decode_role(input int unsigned addr, input int unsigned num_ch);
    if (addr < num_ch)       return ROLE_CMP;
    else if (addr == num_ch) return ROLE_DIV;
    else                     return ROLE_UNUSED;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] div_val,
  output logic          step
);
  logic [DW-1:0] down_q;

  assign step = (down_q == '0);

  always_ff @(posedge clk) begin
    if (rst)       down_q <= '0;
    else if (step) down_q <= div_val;
    else           down_q <= down_q - 1'b1;
  end

  // R2: reload picks the divider value present at the step edge
  p_reload_on_step_r2: assert property (@(posedge clk) disable iff (rst)
    step |=> (down_q == $past(div_val)));
  // R2: between steps the count moves down by one
  p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
    !step |=> (down_q == $past(down_q) - 1'b1));
endmodule

// File: rtl/pwm_step_counter.sv
module pwm_step_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [DW-1:0] count
);
  localparam logic [DW-1:0] TOP = {{(DW-1){1'b1}}, 1'b0};

  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (step) begin
      if (count == TOP)    count <= '0;
      else                 count <= count + 1'b1;
    end
  end

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    count <= TOP);
  p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (step && count == TOP) |=> (count == '0));
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count));
endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cmp_val,
  input  logic [DW-1:0] count,
  output logic          level
);
  assign level = (cmp_val <= count);

  // R5: extremes of the compare range
  p_all_ones_low_r5: assert property (@(posedge clk) disable iff (rst)
    (cmp_val == '1) |-> !level);
  p_zero_high_r5: assert property (@(posedge clk) disable iff (rst)
    (cmp_val == '0) |-> level);
endmodule

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NUM_CH = 2,
  parameter int AW     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        addr,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        rd_data,
  output logic [NUM_CH*DW-1:0] cmp_flat,
  output logic [DW-1:0]        div_val
);
  reg_role_e role;
  assign role = decode_role(int'(addr), NUM_CH);

  logic [DW-1:0] cmp_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst)                                            cmp_q[g] <= '0;
      else if (wr_en && role == ROLE_CMP && int'(addr) == g) cmp_q[g] <= wr_data;
    end
    assign cmp_flat[g*DW +: DW] = cmp_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst)                          div_val <= '0;
    else if (wr_en && role == ROLE_DIV) div_val <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    case (role)
      ROLE_CMP: begin
        for (int i = 0; i < NUM_CH; i++)
          if (int'(addr) == i) rd_data = cmp_q[i];
      end
      ROLE_DIV: rd_data = div_val;
      default:  rd_data = '0;
    endcase
  end

  // R8: writes to an unused address leave every register untouched
  p_unused_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && role == ROLE_UNUSED) |=> ($stable(cmp_flat) && $stable(div_val)));
  // R6: a compare write lands on the next edge
  p_cmp_write_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && role == ROLE_CMP) |=> (rd_data == $past(wr_data) || $past(addr) != addr));
endmodule

// File: rtl/pwm_dual_top.sv
module pwm_dual_top #(
  parameter int DW     = 8,
  parameter int NUM_CH = 2,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr_en,
  input  logic [DW-1:0]     reg_wr_data,
  output logic [DW-1:0]     reg_rd_data,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH*DW-1:0] cmp_flat;
  logic [DW-1:0]        div_val;
  logic                 step;
  logic [DW-1:0]        count;

  pwm_regbank #(.DW(DW), .NUM_CH(NUM_CH), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr_en(reg_wr_en),
    .wr_data(reg_wr_data), .rd_data(reg_rd_data),
    .cmp_flat(cmp_flat), .div_val(div_val)
  );

  pwm_prescaler #(.DW(DW)) u_pre (
    .clk(clk), .rst(rst), .div_val(div_val), .step(step)
  );

  pwm_step_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .count(count)
  );

  // R7: every channel sees the one shared count
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_cmp_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .cmp_val(cmp_flat[g*DW +: DW]),
      .count(count), .level(pwm_out[g])
    );
  end

  // R1: first cycle after reset has both outputs high
  p_reset_high_r1: assert property (@(posedge clk)
    $fell(rst) |-> (pwm_out == '1));
endmodule

// File: tb/test_pwm_dual_top.sv
module test_pwm_dual_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic [1:0] pwm_out;

  int checks = 0;
  int failures = 0;

  pwm_dual_top i_pwm_dual_top (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  // reference model built from the requirements
  logic [7:0] m_cmp0 = 0, m_cmp1 = 0, m_div = 0, m_pre = 0, m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cmp0 <= 0; m_cmp1 <= 0; m_div <= 0; m_pre <= 0; m_cnt <= 0;
    end else begin
      if (m_pre == 0) begin
        m_pre <= m_div;
        m_cnt <= (m_cnt == 8'd254) ? 8'd0 : m_cnt + 8'd1;
      end else m_pre <= m_pre - 8'd1;
      if (reg_wr_en) begin
        if (reg_addr == 2'd0) m_cmp0 <= reg_wr_data;
        if (reg_addr == 2'd1) m_cmp1 <= reg_wr_data;
        if (reg_addr == 2'd2) m_div  <= reg_wr_data;
      end
    end
  end

  function automatic logic exp_level(input logic [7:0] c, input logic [7:0] n);
    return !(c > n);
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cmp0;
      2'd1: return m_cmp1;
      2'd2: return m_div;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: check at the negedge, then drive new inputs
  task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    chk(pwm_out[0] == exp_level(m_cmp0, m_cnt), "R4 ch0 level", pwm_out[0], exp_level(m_cmp0, m_cnt));
    chk(pwm_out[1] == exp_level(m_cmp1, m_cnt), "R7 ch1 level", pwm_out[1], exp_level(m_cmp1, m_cnt));
    chk(reg_rd_data == exp_read(reg_addr), "R8 readback", reg_rd_data, exp_read(reg_addr));
    reg_wr_en = we; reg_addr = a; reg_wr_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd3, 8'h00);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1'b1, a, d);
    cyc(1'b0, a, 8'h00);
  endtask

  task automatic count_low(input int n, output int lo0, output int lo1);
    lo0 = 0; lo1 = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!pwm_out[0]) lo0++;
      if (!pwm_out[1]) lo1++;
    end
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int lo0, lo1, t0, t1;
    logic prev;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(pwm_out == 2'b11, "R1 outputs high", pwm_out, 3);
    for (int a = 0; a < 3; a++) begin
      reg_addr = 2'(a);
      #1;
      chk(reg_rd_data == 8'h00, "R1 register zero", reg_rd_data, 0);
    end

    // R5: extremes held over several periods
    wr(2'd0, 8'hFF); wr(2'd1, 8'h00);
    count_low(600, lo0, lo1);
    chk(lo0 == 600, "R5 FFh constant low", lo0, 600);
    chk(lo1 == 0, "R5 00h constant high", lo1, 0);

    // R6: immediate compare update mid-period
    wr(2'd2, 8'd3);
    idle(37);
    reg_wr_en = 1'b1; reg_addr = 2'd1; reg_wr_data = 8'hFF;
    @(negedge clk);
    chk(pwm_out[1] == 1'b0, "R6 immediate update", pwm_out[1], 0);
    reg_wr_en = 1'b0;

    // R9 / R7: duty ratio with divider 0 and 2
    wr(2'd2, 8'd0); wr(2'd0, 8'd100); wr(2'd1, 8'd200);
    idle(300);
    count_low(255, lo0, lo1);
    chk(lo0 == 100, "R9 ch0 low cycles D=0", lo0, 100);
    chk(lo1 == 200, "R9 ch1 low cycles D=0", lo1, 200);
    wr(2'd2, 8'd2);
    idle(800);
    count_low(765, lo0, lo1);
    chk(lo0 == 300, "R9 ch0 low cycles D=2", lo0, 300);
    chk(lo1 == 600, "R9 ch1 low cycles D=2", lo1, 600);

    // R2 / R3: period between rising edges is 255*(D+1)
    wr(2'd2, 8'd1); wr(2'd0, 8'd128);
    idle(600);
    t0 = 0; t1 = 0; prev = pwm_out[0];
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (pwm_out[0] && !prev) begin
        if (t0 == 0) t0 = i; else if (t1 == 0) t1 = i;
      end
      prev = pwm_out[0];
    end
    chk((t1 - t0) == 510, "R2 R3 period D=1", t1 - t0, 510);

    // R8: unused address ignores writes and reads zero
    wr(2'd3, 8'hAA);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1;
      chk(reg_rd_data == exp_read(2'(a)), "R8 after unused write", reg_rd_data, exp_read(2'(a)));
    end

    // R2: widest divider for a while, model-checked each cycle
    wr(2'd2, 8'hFF);
    idle(3000);

    // random traffic, model-checked each cycle
    for (int i = 0; i < 40000; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      if (a == 2'd2) d = 8'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) begin
        if ($urandom_range(0, 7) == 0) d = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'h00;
        cyc(1'b1, a, d);
      end else cyc(1'b0, a, 8'h00);
    end
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule